// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access. A translation request carries the virtual address, the kind of access (read, write, execute or a permission probe) and a privilege index. Three kinds of request finish at once, without touching memory: physical-mode requests, malformed addresses and kernel superpage addresses. Every other request walks three levels of 8-byte page table entries. The walk starts from a page-table base value and goes out through a small read port that has a request handshake and a response strobe.

One request is in flight at a time. Each result is reported in a single-cycle completion pulse. The pulse carries a 3-bit fault code, the physical address and the granted rights. It is meant to sit behind a translation cache that calls it on a miss.

Top module: `pt_walker`

## Requirements
- R1: A privilege index of 4 or more selects physical mode. The result has fault code 0, `done_pa` equal to the virtual address and `done_prot` = 3'b111, and the walker issues no memory read.
- R2: If bits 63 down to 43 of the virtual address are not all equal, the result is fault code 1 (access violation) with no memory read. This applies unless R1 applies.
- R3: An address with bit 63 set and bits 42:41 = 2'b10 is a superpage. At privilege 0 the result has fault 0, prot 3'b111, and a physical address built from address bits 39:0 plus address bit 40 placed at physical bit 43, with all other bits zero. At privileges 1 to 3 it gives fault code 1.
- R4: The walk reads three entries in order. The first is at `ptbr` + 8*VA[42:33]. The second is at B1 + 8*VA[32:23] and the third at B2 + 8*VA[22:13], where each base Bn is entry bits 63:32 shifted left by 13. On success, `done_pa` is (third entry bits 63:32) << 13, ORed with VA[12:0].
- R5: An entry whose bit 0 (valid) is clear, at any level, ends the walk with fault code 2, and no further read is issued.
- R6: A valid first- or second-level entry whose bit 8 (kernel read enable) is clear gives fault code 1.
- R7: At the third level, privilege p in 0..3 gets read and execute rights from entry bit 8+p, and write rights from entry bit 12+p. `done_prot` is {exec, write, read}. Access codes are 0 read, 1 write, 2 execute and 3 probe (needs nothing). A needed right that is not granted gives fault code 1.
- R8: Entry bits 1, 2 and 3 (fault-on read, write, execute) remove the matching right. If the needed right is then gone, the fault code is 5 for execute, 4 for write and 3 for read, checked in that order. On success, `done_prot` shows the rights left after removal.
- R9: Any non-zero fault code comes with `done_pa` = 0 and `done_prot` = 0.
- R10: `req_ready` is high only when idle. At most one memory read is outstanding. `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen.
- R11: `done_valid` is a single-cycle pulse per accepted request. Immediate results arrive one cycle after acceptance. With the read port always ready, a walk takes two cycles per level read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this edge |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 probe |
| req_priv | input | 3 | Privilege index: 0 kernel .. 3 user, 4 or more physical |
| ptbr | input | 64 | First-level table base, sampled at acceptance |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 3 | 0 ok, 1 access violation, 2 not valid, 3/4/5 fault-on read/write/execute |
| done_pa | output | 64 | Physical address |
| done_prot | output | 3 | Granted rights {exec, write, read} |

## Verification
Physical-mode, malformed and superpage results are registered at the acceptance edge. They are therefore sampled at the first falling edge after acceptance, and the bench requires zero extra wait cycles for them. With the read port held ready, each level takes one edge for the handshake and one for the response. A full walk therefore shows its pulse six cycles after that first sample point, and a first-level fault shows it two cycles after. The bench counts falling edges until the pulse and compares the count with these figures. It also checks that the pulse is gone one cycle later. Under a toggling ready, only the values and the read order are compared, because the latency then depends on the stall pattern.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ACCESS   = 3'd1,
    FLT_INVALID  = 3'd2,
    FLT_ON_READ  = 3'd3,
    FLT_ON_WRITE = 3'd4,
    FLT_ON_EXEC  = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_L1   = 3'd1,
    ST_L2   = 3'd2,
    ST_L3   = 3'd3,
    ST_DONE = 3'd4
  } walk_state_e;

  // entry bit positions
  localparam int BIT_VALID   = 0;
  localparam int BIT_FO_RD   = 1;
  localparam int BIT_FO_EXEC = 3;
  localparam int BIT_RD_EN0  = 8;
  localparam int BIT_WR_EN0  = 12;

  // rights vector layout {exec, write, read}
  localparam logic [2:0] RIGHT_RD = 3'b001;
  localparam logic [2:0] RIGHT_WR = 3'b010;
  localparam logic [2:0] RIGHT_EX = 3'b100;

  function automatic logic [2:0] need_of(input logic [1:0] acc);
    case (acc)
      2'd0:    need_of = RIGHT_RD;
      2'd1:    need_of = RIGHT_WR;
      2'd2:    need_of = RIGHT_EX;
      default: need_of = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/pt_va_classify.sv
module pt_va_classify
  import pt_walker_pkg::*;
#(
  parameter int VA_W         = 64,
  parameter int PA_W         = 64,
  parameter int VIRT_BITS    = 43,
  parameter int SP_KEEP_BITS = 40,
  parameter int SP_RELOC_BIT = 43
) (
  input  logic [VA_W-1:0] va,
  input  logic [2:0]      priv,
  output logic            imm,
  output logic [2:0]      imm_fault,
  output logic [PA_W-1:0] imm_pa,
  output logic [2:0]      imm_prot
);

  localparam int UPPER_W = VA_W - VIRT_BITS;

  logic [UPPER_W-1:0] upper;
  logic               canon;
  logic               in_super;
  logic               phys_mode;
  logic               kernel;
  logic [PA_W-1:0]    super_pa;

  assign upper     = va[VA_W-1:VIRT_BITS];
  assign canon     = (&upper) | ~(|upper);
  assign in_super  = va[VA_W-1] & (va[VIRT_BITS-1:VIRT_BITS-2] == 2'b10);
  assign phys_mode = priv[2];
  assign kernel    = (priv == 3'd0);

  always_comb begin
    super_pa = '0;
    super_pa[SP_KEEP_BITS-1:0] = va[SP_KEEP_BITS-1:0];
    super_pa[SP_RELOC_BIT]     = va[SP_KEEP_BITS];
  end

  always_comb begin
    imm       = 1'b0;
    imm_fault = FLT_NONE;
    imm_pa    = '0;
    imm_prot  = 3'b000;
    if (phys_mode) begin
      imm      = 1'b1;
      imm_pa   = PA_W'(va);
      imm_prot = 3'b111;
    end else if (!canon) begin
      imm       = 1'b1;
      imm_fault = FLT_ACCESS;
    end else if (in_super) begin
      imm = 1'b1;
      if (kernel) begin
        imm_pa   = super_pa;
        imm_prot = 3'b111;
      end else begin
        imm_fault = FLT_ACCESS;
      end
    end
  end

endmodule

// File: rtl/pt_level_index.sv
module pt_level_index #(
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int IDX_W      = 10,
  parameter int LEVELS     = 3
) (
  input  logic [VA_W-1:0]  va,
  input  logic [1:0]       lvl,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_all [LEVELS];

  // level 0 is the top of the tree and takes the highest index field
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam int LSB = PAGE_SHIFT + (LEVELS - 1 - g) * IDX_W;
    assign idx_all[g] = va[LSB +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (int'(lvl) == i) idx = idx_all[i];
    end
  end

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_walker_pkg::*;
#(
  parameter int PTE_W      = 64,
  parameter int PA_W       = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int FRAME_LSB  = 32
) (
  input  logic [PTE_W-1:0]      pte,
  input  logic                  leaf,
  input  logic [1:0]            priv,
  input  logic [2:0]            need,
  input  logic [PAGE_SHIFT-1:0] offset,
  output logic [2:0]            fault,
  output logic [PA_W-1:0]       frame,
  output logic [PA_W-1:0]       leaf_pa,
  output logic [2:0]            prot
);

  localparam int FRAME_W = PTE_W - FRAME_LSB;

  logic       rd_en;
  logic       wr_en;
  logic [2:0] granted;
  logic [2:0] fo_mask;
  logic [2:0] left;

  assign frame   = PA_W'(pte[PTE_W-1:FRAME_LSB]) << PAGE_SHIFT;
  assign leaf_pa = frame | PA_W'(offset);
  assign rd_en   = pte[BIT_RD_EN0 + int'(priv)];
  assign wr_en   = pte[BIT_WR_EN0 + int'(priv)];
  assign granted = {rd_en, wr_en, rd_en};
  assign fo_mask = pte[BIT_FO_EXEC:BIT_FO_RD];
  assign left    = granted & ~fo_mask;
  assign prot    = left;

  always_comb begin
    fault = FLT_NONE;
    if (!pte[BIT_VALID]) begin
      fault = FLT_INVALID;
    end else if (!leaf) begin
      if (!pte[BIT_RD_EN0]) fault = FLT_ACCESS;
    end else if ((need != 3'b000) && ((granted & need) == 3'b000)) begin
      fault = FLT_ACCESS;
    end else if ((need != 3'b000) && ((left & need) == 3'b000)) begin
      if (need[2])      fault = FLT_ON_EXEC;
      else if (need[1]) fault = FLT_ON_WRITE;
      else              fault = FLT_ON_READ;
    end
  end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_W       = 64,
  parameter int PTE_W      = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int IDX_W      = 10,
  parameter int ENTRY_SH   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_va,
  input  logic [1:0]            req_acc,
  input  logic [2:0]            req_priv,
  input  logic [PA_W-1:0]       ptbr,
  input  logic                  imm,
  input  logic [2:0]            imm_fault,
  input  logic [PA_W-1:0]       imm_pa,
  input  logic [2:0]            imm_prot,
  output logic [VA_W-1:0]       idx_va,
  output logic [1:0]            idx_lvl,
  input  logic [IDX_W-1:0]      idx,
  output logic                  ev_leaf,
  output logic [1:0]            ev_priv,
  output logic [2:0]            ev_need,
  output logic [PAGE_SHIFT-1:0] ev_offset,
  input  logic [2:0]            ev_fault,
  input  logic [PA_W-1:0]       ev_frame,
  input  logic [PA_W-1:0]       ev_pa,
  input  logic [2:0]            ev_prot,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  output logic                  done_valid,
  output logic [2:0]            done_fault,
  output logic [PA_W-1:0]       done_pa,
  output logic [2:0]            done_prot
);

  walk_state_e     state_q;
  logic [VA_W-1:0] va_q;
  logic [1:0]      priv_q;
  logic [2:0]      need_q;
  logic            pending_q;
  logic [PA_W-1:0] idx_off;
  walk_state_e     next_lvl;

  assign req_ready = (state_q == ST_IDLE);
  assign idx_va    = (state_q == ST_IDLE) ? req_va : va_q;
  assign idx_lvl   = (state_q == ST_IDLE) ? 2'd0 :
                     (state_q == ST_L1)   ? 2'd1 : 2'd2;
  assign idx_off   = PA_W'(idx) << ENTRY_SH;
  assign ev_leaf   = (state_q == ST_L3);
  assign ev_priv   = priv_q;
  assign ev_need   = need_q;
  assign ev_offset = va_q[PAGE_SHIFT-1:0];
  assign next_lvl  = (state_q == ST_L1) ? ST_L2 : ST_L3;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      va_q          <= '0;
      priv_q        <= '0;
      need_q        <= '0;
      pending_q     <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done_valid    <= 1'b0;
      done_fault    <= FLT_NONE;
      done_pa       <= '0;
      done_prot     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va;
            priv_q <= req_priv[1:0];
            need_q <= need_of(req_acc);
            if (imm) begin
              done_valid <= 1'b1;
              done_fault <= imm_fault;
              done_pa    <= imm_pa;
              done_prot  <= imm_prot;
              state_q    <= ST_DONE;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= ptbr + idx_off;
              state_q       <= ST_L1;
            end
          end
        end
        ST_L1, ST_L2, ST_L3: begin
          if (mem_req_valid && mem_req_ready) begin
            mem_req_valid <= 1'b0;
            pending_q     <= 1'b1;
          end
          if (pending_q && mem_rsp_valid) begin
            pending_q <= 1'b0;
            if (ev_fault != FLT_NONE) begin
              done_valid <= 1'b1;
              done_fault <= ev_fault;
              done_pa    <= '0;
              done_prot  <= '0;
              state_q    <= ST_DONE;
            end else if (state_q == ST_L3) begin
              done_valid <= 1'b1;
              done_fault <= FLT_NONE;
              done_pa    <= ev_pa;
              done_prot  <= ev_prot;
              state_q    <= ST_DONE;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= ev_frame + idx_off;
              state_q       <= next_lvl;
            end
          end
        end
        default: begin
          done_valid <= 1'b0;
          state_q    <= ST_IDLE;
        end
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
    pending_q |-> !mem_req_valid);

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  p_fault_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (done_valid && (done_fault != 3'd0)) |-> ((done_pa == '0) && (done_prot == 3'b000)));

  p_code_range_r8: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_fault <= 3'd5));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W         = 64,
  parameter int PA_W         = 64,
  parameter int PTE_W        = 64,
  parameter int VIRT_BITS    = 43,
  parameter int PAGE_SHIFT   = 13,
  parameter int IDX_W        = 10,
  parameter int SP_KEEP_BITS = 40,
  parameter int SP_RELOC_BIT = 43
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  input  logic [2:0]       req_priv,
  input  logic [PA_W-1:0]  ptbr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done_valid,
  output logic [2:0]       done_fault,
  output logic [PA_W-1:0]  done_pa,
  output logic [2:0]       done_prot
);

  localparam int LEVELS    = 3;
  localparam int ENTRY_SH  = $clog2(PTE_W / 8);
  localparam int FRAME_LSB = PTE_W / 2;

  logic                  imm;
  logic [2:0]            imm_fault;
  logic [PA_W-1:0]       imm_pa;
  logic [2:0]            imm_prot;
  logic [VA_W-1:0]       idx_va;
  logic [1:0]            idx_lvl;
  logic [IDX_W-1:0]      idx;
  logic                  ev_leaf;
  logic [1:0]            ev_priv;
  logic [2:0]            ev_need;
  logic [PAGE_SHIFT-1:0] ev_offset;
  logic [2:0]            ev_fault;
  logic [PA_W-1:0]       ev_frame;
  logic [PA_W-1:0]       ev_pa;
  logic [2:0]            ev_prot;

  pt_va_classify #(
    .VA_W(VA_W), .PA_W(PA_W), .VIRT_BITS(VIRT_BITS),
    .SP_KEEP_BITS(SP_KEEP_BITS), .SP_RELOC_BIT(SP_RELOC_BIT)
  ) u_classify (
    .va(req_va), .priv(req_priv), .imm(imm), .imm_fault(imm_fault),
    .imm_pa(imm_pa), .imm_prot(imm_prot)
  );

  pt_level_index #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W), .LEVELS(LEVELS)
  ) u_index (
    .va(idx_va), .lvl(idx_lvl), .idx(idx)
  );

  pt_entry_eval #(
    .PTE_W(PTE_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .FRAME_LSB(FRAME_LSB)
  ) u_eval (
    .pte(mem_rsp_data), .leaf(ev_leaf), .priv(ev_priv), .need(ev_need),
    .offset(ev_offset), .fault(ev_fault), .frame(ev_frame), .leaf_pa(ev_pa),
    .prot(ev_prot)
  );

  pt_walk_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .PAGE_SHIFT(PAGE_SHIFT),
    .IDX_W(IDX_W), .ENTRY_SH(ENTRY_SH)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_acc(req_acc), .req_priv(req_priv), .ptbr(ptbr),
    .imm(imm), .imm_fault(imm_fault), .imm_pa(imm_pa), .imm_prot(imm_prot),
    .idx_va(idx_va), .idx_lvl(idx_lvl), .idx(idx),
    .ev_leaf(ev_leaf), .ev_priv(ev_priv), .ev_need(ev_need), .ev_offset(ev_offset),
    .ev_fault(ev_fault), .ev_frame(ev_frame), .ev_pa(ev_pa), .ev_prot(ev_prot),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .done_valid(done_valid), .done_fault(done_fault), .done_pa(done_pa),
    .done_prot(done_prot)
  );

endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] PTBR = 64'h0000_0000_0010_0000;
  localparam logic [63:0] VA   = (64'd1 << 33) | (64'd2 << 23) | (64'd3 << 13) | 64'h5A5;
  localparam logic [63:0] A1   = PTBR + 64'd8;
  localparam logic [63:0] A2   = (64'h200 << 13) + 64'd16;
  localparam logic [63:0] A3   = (64'h300 << 13) + 64'd24;
  localparam logic [63:0] PE1  = {32'h0000_0200, 32'h0000_0101};
  localparam logic [63:0] PE2  = {32'h0000_0300, 32'h0000_0101};
  localparam logic [63:0] PAOK = (64'h1234 << 13) | 64'h5A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic [2:0]  req_priv = '0;
  logic [63:0] ptbr = PTBR;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [2:0]  done_fault;
  logic [63:0] done_pa;
  logic [2:0]  done_prot;

  logic [63:0] tbl [logic [63:0]];
  int          rd_cnt = 0;
  logic [63:0] rd_log [4];
  logic        stall = 1'b0;
  int          errors = 0;
  int          checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_acc(req_acc), .req_priv(req_priv), .ptbr(ptbr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done_valid(done_valid),
    .done_fault(done_fault), .done_pa(done_pa), .done_prot(done_prot)
  );

  // memory model: response one cycle after each accepted read
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= tbl.exists(mem_req_addr) ? tbl[mem_req_addr] : 64'd0;
      rd_log[rd_cnt % 4] <= mem_req_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request, wait for the pulse; lat counts falling edges after the first post-accept one
  task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic [2:0] priv,
                     output int lat, output int nrd);
    int start;
    @(negedge clk);
    start     = rd_cnt;
    req_va    = va;
    req_acc   = acc;
    req_priv  = priv;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    if (!done_valid) chk("R11 result pulse missing", 64'd0, 64'd1);
    nrd = rd_cnt - start;
  endtask

  task automatic after_pulse(input string tag);
    @(negedge clk);
    chk(tag, {63'd0, done_valid}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R10 reset req_ready", {63'd0, req_ready}, 64'd1);
    chk("R10 reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    chk("R11 reset done_valid", {63'd0, done_valid}, 64'd0);
  endtask

  task automatic t_phys;
    int lat, nrd;
    run(64'hDEAD_BEEF_0000_1234, 2'd1, 3'd4, lat, nrd);
    chk("R1 phys fault", {61'd0, done_fault}, 64'd0);
    chk("R1 phys pa", done_pa, 64'hDEAD_BEEF_0000_1234);
    chk("R1 phys prot", {61'd0, done_prot}, 64'd7);
    chk("R1 phys no reads", 64'(nrd), 64'd0);
    chk("R11 phys latency", 64'(lat), 64'd0);
    after_pulse("R11 phys pulse width");
  endtask

  task automatic t_noncanon;
    int lat, nrd;
    run(64'h0000_1000_0000_0000, 2'd0, 3'd0, lat, nrd);
    chk("R2 high bit fault", {61'd0, done_fault}, 64'd1);
    chk("R9 high bit pa", done_pa, 64'd0);
    chk("R2 no reads", 64'(nrd), 64'd0);
    run(64'h8000_0000_0000_0000, 2'd0, 3'd0, lat, nrd);
    chk("R2 sign-only fault", {61'd0, done_fault}, 64'd1);
  endtask

  task automatic t_superpage;
    int lat, nrd;
    run(64'hFFFF_FD12_3456_789A, 2'd1, 3'd0, lat, nrd);
    chk("R3 superpage fault", {61'd0, done_fault}, 64'd0);
    chk("R3 superpage pa", done_pa, 64'h0000_0812_3456_789A);
    chk("R3 superpage prot", {61'd0, done_prot}, 64'd7);
    chk("R3 superpage no reads", 64'(nrd), 64'd0);
    run(64'hFFFF_FD12_3456_789A, 2'd0, 3'd3, lat, nrd);
    chk("R3 superpage user fault", {61'd0, done_fault}, 64'd1);
    chk("R9 superpage user prot", {61'd0, done_prot}, 64'd0);
  endtask

  task automatic t_walk_ok;
    int lat, nrd;
    tbl[A3] = {32'h0000_1234, 32'h0000_1101};
    run(VA, 2'd0, 3'd0, lat, nrd);
    chk("R4 walk fault", {61'd0, done_fault}, 64'd0);
    chk("R4 walk pa", done_pa, PAOK);
    chk("R7 kernel prot", {61'd0, done_prot}, 64'd7);
    chk("R4 read count", 64'(nrd), 64'd3);
    chk("R4 first read addr", rd_log[(rd_cnt - 3) % 4], A1);
    chk("R4 second read addr", rd_log[(rd_cnt - 2) % 4], A2);
    chk("R4 third read addr", rd_log[(rd_cnt - 1) % 4], A3);
    chk("R11 walk latency", 64'(lat), 64'd6);
    after_pulse("R11 walk pulse width");
  endtask

  task automatic t_walk_stall;
    int lat, nrd;
    stall = 1'b1;
    run(VA, 2'd1, 3'd0, lat, nrd);
    stall = 1'b0;
    chk("R10 stalled walk fault", {61'd0, done_fault}, 64'd0);
    chk("R10 stalled walk pa", done_pa, PAOK);
    chk("R10 stalled read count", 64'(nrd), 64'd3);
    chk("R10 stalled third addr", rd_log[(rd_cnt - 1) % 4], A3);
  endtask

  task automatic t_invalid;
    int lat, nrd;
    tbl[A2] = {32'h0000_0300, 32'h0000_0100};
    run(VA, 2'd0, 3'd0, lat, nrd);
    chk("R5 invalid level2 fault", {61'd0, done_fault}, 64'd2);
    chk("R5 stops after level2", 64'(nrd), 64'd2);
    chk("R9 invalid pa", done_pa, 64'd0);
    tbl[A2] = PE2;
    tbl[A3] = {32'h0000_1234, 32'h0000_1100};
    run(VA, 2'd0, 3'd0, lat, nrd);
    chk("R5 invalid leaf fault", {61'd0, done_fault}, 64'd2);
  endtask

  task automatic t_kre;
    int lat, nrd;
    tbl[A1] = {32'h0000_0200, 32'h0000_0001};
    run(VA, 2'd0, 3'd0, lat, nrd);
    chk("R6 level1 no kernel read", {61'd0, done_fault}, 64'd1);
    chk("R6 single read", 64'(nrd), 64'd1);
    chk("R11 level1 fault latency", 64'(lat), 64'd2);
    tbl[A1] = PE1;
  endtask

  task automatic t_perm;
    int lat, nrd;
    tbl[A3] = {32'h0000_1234, 32'h0000_0801};
    run(VA, 2'd1, 3'd3, lat, nrd);
    chk("R7 user write denied", {61'd0, done_fault}, 64'd1);
    run(VA, 2'd0, 3'd3, lat, nrd);
    chk("R7 user read fault", {61'd0, done_fault}, 64'd0);
    chk("R7 user read prot", {61'd0, done_prot}, 64'd5);
    run(VA, 2'd2, 3'd3, lat, nrd);
    chk("R7 user exec fault", {61'd0, done_fault}, 64'd0);
    run(VA, 2'd0, 3'd0, lat, nrd);
    chk("R7 kernel denied on user page", {61'd0, done_fault}, 64'd1);
  endtask

  task automatic t_fault_on;
    int lat, nrd;
    tbl[A3] = {32'h0000_1234, 32'h0000_0803};
    run(VA, 2'd0, 3'd3, lat, nrd);
    chk("R8 fault-on-read", {61'd0, done_fault}, 64'd3);
    chk("R9 fault-on-read prot", {61'd0, done_prot}, 64'd0);
    run(VA, 2'd3, 3'd3, lat, nrd);
    chk("R8 probe fault", {61'd0, done_fault}, 64'd0);
    chk("R8 probe prot after removal", {61'd0, done_prot}, 64'd4);
    tbl[A3] = {32'h0000_1234, 32'h0000_8805};
    run(VA, 2'd1, 3'd3, lat, nrd);
    chk("R8 fault-on-write", {61'd0, done_fault}, 64'd4);
    tbl[A3] = {32'h0000_1234, 32'h0000_0809};
    run(VA, 2'd2, 3'd3, lat, nrd);
    chk("R8 fault-on-exec", {61'd0, done_fault}, 64'd5);
    chk("R9 fault-on-exec pa", done_pa, 64'd0);
  endtask

  initial begin
    tbl[A1] = PE1;
    tbl[A2] = PE2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_phys();
    t_noncanon();
    t_superpage();
    t_walk_ok();
    t_walk_stall();
    t_invalid();
    t_kre();
    t_perm();
    t_fault_on();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule